// File: doc/BRIEF.md
# Three-Digit Chained Seven-Segment Serial Driver

This block turns three BCD digits into the serial stream that a daisy-chain of three serial-in, parallel-out registers with output latches needs to light a three-digit seven-segment display. One register sits behind each digit. A rising edge on the trigger input captures the three digit codes and decodes each one to an eight-bit segment byte. The block then clocks all 24 bits out on a serial clock and data pair and raises a latch strobe so that the external registers copy their contents to the display.

The serial clock is built from two equal half-periods of a programmable number of system clocks. The data bit changes only while the serial clock is low, so every rising edge sees a settled bit. The bit order puts the rightmost digit first, which makes each byte come to rest in the correct register of the chain. A parameter picks which digit, if any, shows its decimal point. The block takes a new refresh only when it is idle.

Top module: `seg_chain_driver`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `ser_clk`, `ser_data` and `latch_out` are all low.
- R2: A refresh starts on the clock edge where `trigger` is first seen high after being low. It uses the digit values present at that edge, and later changes to the digit inputs do not alter the frame being sent.
- R3: A refresh sends exactly 24 bits, one per rising edge of `ser_clk`. The first byte belongs to `digit2_bcd`, the second to `digit1_bcd` and the third to `digit0_bcd`. Each byte is sent most significant bit first, with the bit layout {dp, g, f, e, d, c, b, a}.
- R4: Segment bits are active high. Digits 0 to 9 give these segment fields (dp excluded, same bit layout): 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).
- R5: Codes 10 to 15 give a segment field of 00 (all segments off).
- R6: Parameter DOT_POS set to k in 1..3 lights the dp bit of the k-th digit counted from the left (1 means `digit0_bcd`, 3 means `digit2_bcd`). All other dp bits are 0, and DOT_POS = 0 lights none.
- R7: Each bit period of `ser_clk` is low for STEP_CYCLES system clocks and then high for STEP_CYCLES system clocks.
- R8: `ser_data` does not change while `ser_clk` is high, nor on the edge where `ser_clk` rises.
- R9: `latch_out` stays low while bits are shifting. It goes high right after the 24th high half-period and stays high for STEP_CYCLES clocks, with `ser_clk` low throughout. The block then returns to idle with all three outputs low.
- R10: A rising edge on `trigger` during a refresh, including the latch phase, is ignored and produces no additional frame.
- R11: Holding `trigger` high produces only one refresh. A new refresh needs a fresh low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trigger | input | 1 | Refresh request; its rising edge starts a frame |
| digit0_bcd | input | 4 | BCD code of the leftmost digit |
| digit1_bcd | input | 4 | BCD code of the middle digit |
| digit2_bcd | input | 4 | BCD code of the rightmost digit |
| ser_clk | output | 1 | Shift clock to the register chain |
| ser_data | output | 1 | Serial data to the register chain |
| latch_out | output | 1 | Latch strobe to the register chain; rising edge updates the display |

## Verification
The bench builds the driver with STEP_CYCLES = 3 and DOT_POS = 3. A step longer than one clock lets the bench measure both half-periods and the latch width as counts that a single-cycle step could not tell apart. Lighting the dot on the rightmost digit puts a set dp bit in the very first bit of every frame, so a reversed byte order or bit order inside a byte shows up at once. The parameter value DOT_POS = 0 is not built by the bench.

// File: rtl/seg_chain_pkg.sv
// Package: seg_chain_pkg
// Shared sizes and the controller state type for the chained display driver.
package seg_chain_pkg;
    localparam int SEG_BITS    = 8;   // seven segments plus decimal point
    localparam int BCD_BITS    = 4;
    localparam int DIGIT_COUNT = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } chain_state_t;
endpackage

// File: rtl/bcd_seg_decode.sv
// Module: bcd_seg_decode
// Converts one BCD code to an active-high segment byte laid out as
// {dp, g, f, e, d, c, b, a}. Codes above nine blank the digit.
// Assumes: purely combinational; the dot is fixed by LIGHT_DOT.
module bcd_seg_decode
    import seg_chain_pkg::*;
#(
    parameter bit LIGHT_DOT = 1'b0
) (
    input  logic [BCD_BITS-1:0] bcd_in,
    output logic [SEG_BITS-1:0] seg_out
);
    logic [SEG_BITS-2:0] shape;

    // Purpose: map the digit value to its seven-segment shape.
    always_comb begin
        case (bcd_in)
            4'd0:    shape = 7'b011_1111;
            4'd1:    shape = 7'b000_0110;
            4'd2:    shape = 7'b101_1011;
            4'd3:    shape = 7'b100_1111;
            4'd4:    shape = 7'b110_0110;
            4'd5:    shape = 7'b110_1101;
            4'd6:    shape = 7'b111_1101;
            4'd7:    shape = 7'b000_0111;
            4'd8:    shape = 7'b111_1111;
            4'd9:    shape = 7'b110_1111;
            default: shape = 7'b000_0000;
        endcase
    end

    assign seg_out = {LIGHT_DOT, shape};
endmodule

// File: rtl/trig_edge_detect.sv
// Module: trig_edge_detect
// Flags the cycle in which the trigger input is high after being low.
// Assumes: trigger is synchronous to clk. The history register resets
// high, so a trigger already high when reset ends starts nothing.
module trig_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise_out
);
    logic trig_q;

    // Purpose: remember the trigger level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b1;
        else        trig_q <= trig_in;
    end

    assign rise_out = trig_in & ~trig_q;
endmodule

// File: rtl/step_timer.sv
// Module: step_timer
// Counts system clocks while enabled and pulses step_done on the last
// clock of each step of STEP_CYCLES clocks. It is cleared whenever idle.
// Assumes: STEP_CYCLES >= 1.
module step_timer #(
    parameter int STEP_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_done
);
    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: advance within a step and wrap at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)         cnt <= '0;
        else if (cnt == CNT_LAST)   cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assign step_done = run && (cnt == CNT_LAST);
endmodule

// File: rtl/frame_serializer.sv
// Module: frame_serializer
// Sends a parallel frame out MSB first. Each bit gets a low step and then
// a high step of the serial clock, and the frame ends with a latch step.
// Assumes: start is a one-cycle pulse; it is accepted only when idle.
module frame_serializer
    import seg_chain_pkg::*;
#(
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  step_done,
    output logic                  timer_run,
    output logic                  ser_clk,
    output logic                  ser_data,
    output logic                  latch_out
);
    localparam int IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    chain_state_t          state;
    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      bit_idx;
    logic                  phase_hi;
    logic                  latch_q;

    // Purpose: sequence load, shift and latch steps of one refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            phase_hi <= 1'b0;
            latch_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        shreg    <= frame_in;
                        bit_idx  <= '0;
                        phase_hi <= 1'b0;
                        state    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (step_done) begin
                        if (!phase_hi) begin
                            phase_hi <= 1'b1;
                        end else begin
                            phase_hi <= 1'b0;
                            shreg    <= {shreg[FRAME_BITS-2:0], 1'b0};
                            if (bit_idx == IDX_LAST) begin
                                latch_q <= 1'b1;
                                state   <= ST_LATCH;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_LATCH: begin
                    if (step_done) begin
                        latch_q <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign timer_run = (state != ST_IDLE);
    assign ser_clk   = phase_hi;
    assign ser_data  = shreg[FRAME_BITS-1];
    assign latch_out = latch_q;
endmodule

// File: rtl/seg_chain_driver.sv
// Module: seg_chain_driver
// Top level: on a trigger rising edge, decodes three BCD digits and shifts
// them into a chain of three display registers, rightmost digit first,
// then strobes the latch line.
// Assumes: trigger toggles no faster than clk; DOT_POS in 0..3.
module seg_chain_driver
    import seg_chain_pkg::*;
#(
    parameter int STEP_CYCLES = 25,
    parameter int DOT_POS     = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trigger,
    input  logic [BCD_BITS-1:0] digit0_bcd,
    input  logic [BCD_BITS-1:0] digit1_bcd,
    input  logic [BCD_BITS-1:0] digit2_bcd,
    output logic                ser_clk,
    output logic                ser_data,
    output logic                latch_out
);
    localparam int FRAME_BITS = SEG_BITS * DIGIT_COUNT;

    logic [BCD_BITS-1:0]   digit_bcd [DIGIT_COUNT];
    logic [FRAME_BITS-1:0] frame;
    logic                  start_pulse;
    logic                  timer_run;
    logic                  step_done;

    assign digit_bcd[0] = digit0_bcd;
    assign digit_bcd[1] = digit1_bcd;
    assign digit_bcd[2] = digit2_bcd;

    // One decoder per digit; the leftmost digit lands in the low byte so it
    // leaves the serializer last.
    for (genvar g = 0; g < DIGIT_COUNT; g++) begin : g_digit
        bcd_seg_decode #(
            .LIGHT_DOT(DOT_POS == g + 1)
        ) u_dec (
            .bcd_in (digit_bcd[g]),
            .seg_out(frame[g*SEG_BITS +: SEG_BITS])
        );
    end

    trig_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trigger),
        .rise_out(start_pulse)
    );

    step_timer #(
        .STEP_CYCLES(STEP_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .step_done(step_done)
    );

    frame_serializer #(
        .FRAME_BITS(FRAME_BITS)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_pulse),
        .frame_in (frame),
        .step_done(step_done),
        .timer_run(timer_run),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .latch_out(latch_out)
    );
endmodule

// File: rtl/seg_chain_checker.sv
// Module: seg_chain_checker
// Timing properties of the serial output, attached to the top by bind.
module seg_chain_checker #(
    parameter int STEP_CYCLES = 25,
    parameter int FRAME_BITS  = 24
) (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic ser_data,
    input logic latch_out
);
    logic [31:0] hi_run;
    logic [31:0] lat_run;
    logic [31:0] rise_cnt;
    logic        sclk_q;

    // Purpose: measure high runs, latch width and rises since the last latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run   <= '0;
            lat_run  <= '0;
            rise_cnt <= '0;
            sclk_q   <= 1'b0;
        end else begin
            sclk_q  <= ser_clk;
            hi_run  <= ser_clk   ? hi_run + 1  : '0;
            lat_run <= latch_out ? lat_run + 1 : '0;
            if (ser_clk && !sclk_q) rise_cnt <= rise_cnt + 1;
            else if (latch_out)     rise_cnt <= '0;
        end
    end

    p_high_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> hi_run == 32'(STEP_CYCLES));

    p_high_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> hi_run < 32'(STEP_CYCLES));

    p_data_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

    p_data_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    p_latch_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_out) |-> lat_run == 32'(STEP_CYCLES));

    p_latch_clk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        latch_out |-> !ser_clk);

    p_frame_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_out) |-> rise_cnt == 32'(FRAME_BITS));
endmodule

bind seg_chain_driver seg_chain_checker #(
    .STEP_CYCLES(STEP_CYCLES),
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .latch_out(latch_out)
);

// File: tb/sim_seg_chain_driver.sv
module sim_seg_chain_driver;
    localparam int STEP = 3;
    localparam int DOT  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trigger = 1'b0;
    logic [3:0] d0 = '0, d1 = '0, d2 = '0;
    logic       ser_clk, ser_data, latch_out;

    int n_chk = 0;
    int n_fail = 0;
    int pushes = 0;
    int frames = 0;
    bit done = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    seg_chain_driver #(.STEP_CYCLES(STEP), .DOT_POS(DOT)) u0 (
        .clk(clk), .rst_n(rst_n), .trigger(trigger),
        .digit0_bcd(d0), .digit1_bcd(d1), .digit2_bcd(d2),
        .ser_clk(ser_clk), .ser_data(ser_data), .latch_out(latch_out)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Segment fields from R4/R5, dp from R6, layout {dp,g..a}.
    function automatic logic [7:0] seg_byte(input logic [3:0] v, input bit dot);
        logic [7:0] s;
        case (v)
            4'd0: s = 8'h3F; 4'd1: s = 8'h06; 4'd2: s = 8'h5B; 4'd3: s = 8'h4F;
            4'd4: s = 8'h66; 4'd5: s = 8'h6D; 4'd6: s = 8'h7D; 4'd7: s = 8'h07;
            4'd8: s = 8'h7F; 4'd9: s = 8'h6F; default: s = 8'h00;
        endcase
        return s | (dot ? 8'h80 : 8'h00);
    endfunction

    // R3: rightmost digit byte goes first.
    function automatic logic [23:0] exp_frame(input logic [3:0] a, b, c);
        return {seg_byte(c, DOT == 3), seg_byte(b, DOT == 2), seg_byte(a, DOT == 1)};
    endfunction

    // Monitor: collects bits on serial clock rises, scores frames at latch.
    logic        sclk_p = 1'b0, lat_p = 1'b0, data_p = 1'b0;
    int          low_run = 0, hi_run = 0, lat_w = 0, bits = 0;
    logic [23:0] got = '0;
    bit          r8_bad = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk && !sclk_p) begin
                if (bits > 0) check(low_run == STEP, "R7 low half", low_run, STEP);
                got = {got[22:0], ser_data};
                bits++;
            end
            if (!ser_clk && sclk_p) check(hi_run == STEP, "R7 high half", hi_run, STEP);
            if (ser_clk && sclk_p && ser_data != data_p) r8_bad = 1'b1;
            if (ser_clk) begin
                hi_run = sclk_p ? hi_run + 1 : 1;
            end else begin
                low_run = sclk_p ? 1 : low_run + 1;
            end
            if (latch_out && !lat_p) begin
                frames++;
                check(bits == 24, "R3 bit count", bits, 24);
                check(!ser_clk, "R9 clock low at latch", ser_clk, 0);
                check(!r8_bad, "R8 data moved while clock high", r8_bad, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected frame", got, 0);
                end else begin
                    logic [23:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(got == e, {t, " frame content"}, got, e);
                end
                r8_bad = 1'b0;
                bits = 0;
                lat_w = 0;
            end
            if (latch_out) lat_w++;
            if (!latch_out && lat_p) check(lat_w == STEP, "R9 latch width", lat_w, STEP);
            if (!latch_out && bits != 0 && !ser_clk && !sclk_p && low_run > STEP + 1)
                check(1'b0, "R9 stalled shift", bits, 0);
        end
        sclk_p = ser_clk;
        lat_p  = latch_out;
        data_p = ser_data;
    end

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: start a refresh, then scramble the digits (R2) and drop trigger.
    task automatic refresh(input logic [3:0] a, b, c, input string tag, input int hold);
        @(negedge clk);
        d0 = a; d1 = b; d2 = c;
        trigger = 1'b1;
        exp_q.push_back(exp_frame(a, b, c));
        tag_q.push_back(tag);
        pushes++;
        @(negedge clk);
        d0 = ~a; d1 = ~b; d2 = ~c;
        repeat (hold) @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic finish_frame;
        @(negedge latch_out);
        idle_wait(4);
        check(!ser_clk && !ser_data && !latch_out, "R9 idle after refresh",
              {ser_clk, ser_data, latch_out}, 0);
    endtask

    initial begin
        idle_wait(3);
        check(!ser_clk, "R1 ser_clk in reset", ser_clk, 0);
        check(!ser_data, "R1 ser_data in reset", ser_data, 0);
        check(!latch_out, "R1 latch_out in reset", latch_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({ser_clk, ser_data, latch_out} == 3'b000, "R1 after reset",
              {ser_clk, ser_data, latch_out}, 0);

        refresh(4'd0, 4'd1, 4'd2, "R4", 2);  finish_frame();
        refresh(4'd3, 4'd4, 4'd5, "R4", 0);  finish_frame();
        refresh(4'd6, 4'd7, 4'd8, "R4", 5);  finish_frame();
        refresh(4'd9, 4'd0, 4'd9, "R2", 1);  finish_frame();
        refresh(4'd10, 4'd12, 4'd15, "R5", 1); finish_frame();
        refresh(4'd11, 4'd5, 4'd13, "R6", 1);  finish_frame();
        refresh(4'd8, 4'd8, 4'd8, "R6", 1);    finish_frame();

        // R10: extra trigger edges mid-shift and during the latch step.
        refresh(4'd1, 4'd2, 4'd3, "R10", 1);
        idle_wait(30);
        d0 = 4'd7; d1 = 4'd7; d2 = 4'd7;
        trigger = 1'b1; idle_wait(2); trigger = 1'b0;
        @(posedge latch_out);
        @(negedge clk);
        trigger = 1'b1; @(negedge clk); trigger = 1'b0;
        finish_frame();
        idle_wait(200);
        check(frames == pushes, "R10 frame count", frames, pushes);

        // R11: trigger held high for far longer than a frame.
        refresh(4'd5, 4'd6, 4'd7, "R11", 400);
        idle_wait(200);
        check(frames == pushes, "R11 frame count", frames, pushes);
        check(exp_q.size() == 0, "R11 pending frames", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule